// File: doc/BRIEF.md
# Write-Sequence Feature Unlock Checker

This block watches byte writes that a host makes to one I/O port and recognises a fixed 17-byte unlock pattern. It does not hold the pattern in a table. A small generator rebuilds the middle part of the pattern one step at a time, using a fixed shuffle of the bits of the previous byte.

The result is a sticky unlocked flag. While the flag is set, one extra mode register in the display controller accepts writes through the ordinary controller-register write path. When the flag is cleared again, the register stops accepting writes but keeps the value it already holds. The host CPU bus, video timing and the other controller registers are outside this block.

Top module: `seq_unlock_gate`

## Requirements
- R1: A synchronous active-high reset clears `unlocked` to 0, clears `ext_reg` to 0 and returns the pattern tracker to idle.
- R2: Only strobed writes whose high address byte is 0xBC advance or disturb the tracker. Writes to any other port leave the tracker position and `unlocked` unchanged.
- R3: The accepted pattern is FF, 00, FF, 77, B3, 51, A8, D4, 62, 39, 9C, 46, 2B, 15, 8A, then the decision byte, then EE. From the third byte on, each byte up to the decision byte equals f(previous), where f(a) = ((a>>1)&0x77) | ((a^(a<<3))&0x80) | (((a<<2)^(a<<3))&0x08), truncated to 8 bits.
- R4: At the decision position (the 16th byte), the value 0xCD sets `unlocked` on the clock edge that takes the write. Any other value clears it on that edge.
- R5: In the middle of the pattern, a write to 0xBC that differs from the expected byte sends the tracker back to idle. If that write is 0xFF, it counts as the first byte of a new pattern.
- R6: The extended register is selected by a write to port 0x7F whose data bits [7:5] are 101. While `unlocked` is 1, `ext_we` is high in that same cycle and `ext_reg` takes data bits [4:0] on the following edge.
- R7: Clearing `unlocked` leaves the value already held in `ext_reg` unchanged.
- R8: The outcome is applied at the decision byte and does not wait for the trailing EE. After the trailing byte, or after a wrong byte in that position, the tracker is idle and a new pattern can begin.
- R9: While `unlocked` is 0, `ext_we` stays low and `ext_reg` ignores extended-register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Port-write strobe, one write per cycle |
| wr_port_hi | input | 8 | High byte of the port address |
| wr_data | input | 8 | Written data byte |
| unlocked | output | 1 | Sticky unlock flag |
| ext_we | output | 1 | Extended-register write enable (combinational) |
| ext_reg | output | 5 | Extended mode register contents |

## Verification
The assertions assume that every write lasts exactly one strobed cycle and that `wr_port_hi` and `wr_data` hold steady around the edge that samples them. They also assume that reset is applied before any write is given. The bench drives every input on the falling edge and keeps it for a full period. It asserts reset first, and it releases reset between scenarios only while the strobe is low. Inside these bounds, the stimulus mixes writes to the pattern port with writes to the controller port and to unrelated ports. This lets the properties that tie `unlocked` to the pattern port, and `ext_reg` to `ext_we`, see both kinds of traffic.

// File: rtl/seq_unlock_pkg.sv
package seq_unlock_pkg;
    localparam int BYTE_W     = 8;
    localparam int SEQ_LEN    = 17;
    localparam int POS_W      = $clog2(SEQ_LEN);
    localparam int CHAIN_LO   = 2;
    localparam int DECIDE_POS = 15;
    localparam int CHAIN_HI   = DECIDE_POS - 1;
    localparam int TAIL_POS   = SEQ_LEN - 1;
    localparam int EXT_W      = 5;
    localparam int SEL_W      = BYTE_W - EXT_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [EXT_W-1:0]  ext_t;

    localparam byte_t START_B    = 8'hFF;
    localparam byte_t SECOND_B   = 8'h00;
    localparam byte_t CHAIN_SEED = 8'hFF;
    localparam byte_t TAIL_B     = 8'hEE;
    localparam byte_t SEQ_PORT_D = 8'hBC;
    localparam byte_t CTL_PORT_D = 8'h7F;
    localparam logic [SEL_W-1:0] EXT_SEL_D = 3'b101;

    typedef struct packed {
        logic  hit;
        byte_t data;
    } seq_wr_t;

    typedef struct packed {
        logic load;
        logic step;
    } gen_cmd_t;

    function automatic byte_t next_code(byte_t a);
        byte_t r;
        r = ((a >> 1) & 8'h77)
          | ((a ^ (a << 3)) & 8'h80)
          | (((a << 2) ^ (a << 3)) & 8'h08);
        return r;
    endfunction

    function automatic pos_t pos_at(int i);
        return pos_t'(i);
    endfunction
endpackage

// File: rtl/seq_code_gen.sv
module seq_code_gen
    import seq_unlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gen_cmd_t cmd,
    output byte_t    code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= CHAIN_SEED;
        end else if (cmd.load) begin
            code <= CHAIN_SEED;
        end else if (cmd.step) begin
            code <= next_code(code);
        end
    end
endmodule

// File: rtl/seq_tracker.sv
module seq_tracker
    import seq_unlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_wr_t  wr,
    input  byte_t    code,
    output gen_cmd_t cmd,
    output logic     unlocked
);
    pos_t  pos, pos_n;
    byte_t expect_b;
    logic  unl_n;

    always_comb begin
        if (pos == pos_at(0))             expect_b = START_B;
        else if (pos == pos_at(1))        expect_b = SECOND_B;
        else if (pos == pos_at(TAIL_POS)) expect_b = TAIL_B;
        else                              expect_b = code;
    end

    always_comb begin
        pos_n    = pos;
        unl_n    = unlocked;
        cmd      = '0;
        if (wr.hit) begin
            if (pos == pos_at(DECIDE_POS)) begin
                unl_n = (wr.data == code);
                pos_n = pos + pos_at(1);
            end else if (wr.data == expect_b) begin
                pos_n    = (pos == pos_at(TAIL_POS)) ? pos_at(0) : pos + pos_at(1);
                cmd.load = (pos == pos_at(1));
                cmd.step = (pos >= pos_at(CHAIN_LO)) && (pos <= pos_at(CHAIN_HI));
            end else begin
                pos_n = (wr.data == START_B) ? pos_at(1) : pos_at(0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            unlocked <= 1'b0;
        end else begin
            pos      <= pos_n;
            unlocked <= unl_n;
        end
    end
endmodule

// File: rtl/seq_ext_reg.sv
module seq_ext_reg
    import seq_unlock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  ext_t din,
    output ext_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= din;
        end
    end
endmodule

// File: rtl/seq_unlock_gate.sv
module seq_unlock_gate
    import seq_unlock_pkg::*;
#(
    parameter byte_t SEQ_PORT = SEQ_PORT_D,
    parameter byte_t CTL_PORT = CTL_PORT_D,
    parameter logic [SEL_W-1:0] EXT_SEL = EXT_SEL_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_port_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              unlocked,
    output logic              ext_we,
    output logic [EXT_W-1:0]  ext_reg
);
    seq_wr_t  seq_wr;
    gen_cmd_t gen_cmd;
    byte_t    gen_code;

    always_comb begin
        seq_wr.hit  = wr_stb && (wr_port_hi == SEQ_PORT);
        seq_wr.data = wr_data;
    end

    assign ext_we = wr_stb && (wr_port_hi == CTL_PORT)
                 && (wr_data[BYTE_W-1:EXT_W] == EXT_SEL) && unlocked;

    seq_code_gen gen_i (
        .clk  (clk),
        .rst  (rst),
        .cmd  (gen_cmd),
        .code (gen_code)
    );

    seq_tracker trk_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (seq_wr),
        .code     (gen_code),
        .cmd      (gen_cmd),
        .unlocked (unlocked)
    );

    seq_ext_reg ext_i (
        .clk (clk),
        .rst (rst),
        .we  (ext_we),
        .din (wr_data[EXT_W-1:0]),
        .q   (ext_reg)
    );
endmodule

// File: rtl/seq_unlock_chk.sv
module seq_unlock_chk
    import seq_unlock_pkg::*;
#(
    parameter byte_t SEQ_PORT = SEQ_PORT_D
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic [BYTE_W-1:0] wr_port_hi,
    input logic [BYTE_W-1:0] wr_data,
    input logic              unlocked,
    input logic              ext_we,
    input logic [EXT_W-1:0]  ext_reg
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!unlocked && ext_reg == '0));

    assert_other_port_keeps_flag_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && wr_port_hi == SEQ_PORT) |=> $stable(unlocked));

    assert_ext_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
        ext_we |=> (ext_reg == $past(wr_data[EXT_W-1:0])));

    assert_ext_needs_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        ext_we |-> wr_stb);

    assert_ext_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ext_we |=> $stable(ext_reg));

    assert_locked_no_we_R9: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !ext_we);
endmodule

bind seq_unlock_gate seq_unlock_chk #(.SEQ_PORT(SEQ_PORT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .wr_port_hi (wr_port_hi),
    .wr_data    (wr_data),
    .unlocked   (unlocked),
    .ext_we     (ext_we),
    .ext_reg    (ext_reg)
);

// File: tb/seq_unlock_gate_tb.sv
module seq_unlock_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_port_hi = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       unlocked, ext_we;
    logic [4:0] ext_reg;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    logic [7:0] pat [17] = '{8'hFF, 8'h00, 8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4,
                             8'h62, 8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};

    // reference model state
    int         m_idx = 0;
    bit         m_unl = 1'b0;
    logic [4:0] m_reg = 5'd0;

    always #4 clk = ~clk;

    seq_unlock_gate dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_port_hi(wr_port_hi),
        .wr_data(wr_data), .unlocked(unlocked), .ext_we(ext_we), .ext_reg(ext_reg)
    );

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic model_step(bit stb, logic [7:0] port, logic [7:0] d);
        if (stb && port == 8'hBC) begin
            if (m_idx == 15) begin
                m_unl = (d == 8'hCD);
                m_idx = 16;
            end else if (d == pat[m_idx]) begin
                m_idx = (m_idx == 16) ? 0 : m_idx + 1;
            end else begin
                m_idx = (d == 8'hFF) ? 1 : 0;
            end
        end
        if (stb && port == 8'h7F && d[7:5] == 3'b101 && m_unl) m_reg = d[4:0];
    endtask

    task automatic cyc(bit stb, logic [7:0] port, logic [7:0] d);
        bit exp_we;
        @(negedge clk);
        check({cur_req, " unlocked"}, int'(unlocked), int'(m_unl));
        check({cur_req, " ext_reg"}, int'(ext_reg), int'(m_reg));
        wr_stb = stb; wr_port_hi = port; wr_data = d;
        exp_we = stb && port == 8'h7F && d[7:5] == 3'b101 && m_unl;
        #1;
        check({cur_req, " ext_we"}, int'(ext_we), int'(exp_we));
        @(posedge clk);
        model_step(stb, port, d);
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_stb = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_idx = 0; m_unl = 1'b0; m_reg = 5'd0;
    endtask

    task automatic send_range(int first, int last, logic [7:0] decide, bit mix);
        for (int i = first; i <= last; i++) begin
            cyc(1'b1, 8'hBC, (i == 15) ? decide : pat[i]);
            if (mix) begin
                cyc(1'b1, 8'h7F, 8'h20);
                cyc(1'b1, 8'h3C, pat[i] ^ 8'h5A);
                cyc(1'b1, 8'hBD, 8'hFF);
            end
        end
    endtask

    initial begin
        do_reset();
        // R1: reset values
        idle();
        check("R1 reset unlocked", int'(unlocked), 0);
        check("R1 reset ext_reg", int'(ext_reg), 0);

        // R9: ext write ignored while locked
        cur_req = "R9";
        cyc(1'b1, 8'h7F, 8'hB5);
        idle();
        check("R9 locked write ignored", int'(ext_reg), 0);

        // R3/R4: full pattern with 0xCD unlocks
        cur_req = "R3";
        send_range(0, 14, 8'hCD, 1'b0);
        cur_req = "R4";
        send_range(15, 15, 8'hCD, 1'b0);
        idle();
        check("R4 unlocked after CD decision", int'(unlocked), 1);
        // R8: flag already set before trailing byte
        cur_req = "R8";
        send_range(16, 16, 8'hCD, 1'b0);
        idle();

        // R6: ext write accepted
        cur_req = "R6";
        cyc(1'b1, 8'h7F, 8'hA9);
        idle();
        check("R6 ext_reg loaded", int'(ext_reg), 9);
        cyc(1'b1, 8'h7F, 8'h89);   // wrong selector
        idle();
        check("R6 wrong selector ignored", int'(ext_reg), 9);

        // R4/R7: wrong decision byte locks, register kept
        cur_req = "R7";
        send_range(0, 16, 8'hCC, 1'b0);
        idle();
        check("R4 locked after wrong decision", int'(unlocked), 0);
        check("R7 ext_reg kept after lock", int'(ext_reg), 9);
        cur_req = "R9";
        cyc(1'b1, 8'h7F, 8'hBF);
        idle();
        check("R9 write after lock ignored", int'(ext_reg), 9);

        // R2: interleaved foreign writes do not disturb the tracker
        cur_req = "R2";
        send_range(0, 16, 8'hCD, 1'b1);
        idle();
        check("R2 unlocked through interleave", int'(unlocked), 1);

        // R5: broken pattern does not unlock
        cur_req = "R5";
        send_range(0, 16, 8'h00, 1'b0);   // lock first
        send_range(0, 5, 8'hCD, 1'b0);
        cyc(1'b1, 8'hBC, 8'h42);
        send_range(6, 16, 8'hCD, 1'b0);
        idle();
        check("R5 broken pattern stays locked", int'(unlocked), 0);
        // R5: FF mid-pattern restarts
        send_range(0, 4, 8'hCD, 1'b0);
        cyc(1'b1, 8'hBC, 8'hFF);
        send_range(1, 16, 8'hCD, 1'b0);
        idle();
        check("R5 FF restart unlocks", int'(unlocked), 1);

        // R8: wrong trailing byte keeps outcome, tracker idle afterwards
        cur_req = "R8";
        send_range(0, 15, 8'h11, 1'b0);
        cyc(1'b1, 8'hBC, 8'h33);
        idle();
        check("R8 outcome kept despite bad tail", int'(unlocked), 0);
        send_range(0, 15, 8'hCD, 1'b0);
        idle();
        check("R8 new pattern after bad tail", int'(unlocked), 1);
        send_range(16, 16, 8'hCD, 1'b0);
        cyc(1'b1, 8'h7F, 8'hB3);
        idle();

        // R1: reset while unlocked
        cur_req = "R1";
        do_reset();
        idle();
        check("R1 reset clears flag", int'(unlocked), 0);
        check("R1 reset clears ext_reg", int'(ext_reg), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule